// File: doc/BRIEF.md
# SMT Issue Slot Scheduler

This block picks, in every clock cycle, up to eight ready entries of a shared instruction queue in a simultaneous multithreaded core. Any mix of threads may take part in the same cycle. Each pick is routed to a functional-unit pool that is fully pipelined: four integer ALUs, one multiply/divide unit, three memory ports and two floating-point ALUs. Because every unit accepts one new operation per cycle, the number of each unit type is the per-cycle limit on grants of that type. For every pick, the block reports the cycle in which its result will be written back, so that the result bus can be booked.

A policy input sets the ordering. Oldest-first ranks entries by age stamp only. Branch-first moves ready branches ahead of all other work, so that a misprediction is resolved sooner. Speculative-last moves speculative entries behind all non-speculative work. A cap input limits how many instructions a single thread may issue in one cycle. Selection is greedy: an entry that is blocked by its unit type or by its thread cap is skipped, and entries of lower priority may still issue.

Top module: `smt_issue_sched`

## Requirements
- R1: While `rst_n` is low, no entry is granted, no slot is valid, and the internal cycle count is held at 0.
- R2: An entry is granted only when both its valid bit and its ready bit are 1.
- R3: At most 8 entries are granted per cycle. The valid slots form a contiguous run starting at slot 0, and slot 0 holds the entry of highest priority.
- R4: Unit-type codes are 0 = integer ALU, 1 = multiply/divide, 2 = memory port and 3 = floating-point ALU. Per cycle, at most 4, 1, 3 and 2 entries of those codes are granted.
- R5: With policy code 0, a smaller age stamp means an older entry and is preferred. When age stamps are equal, the lower queue index is preferred.
- R6: The cap code sets the per-thread limit per cycle: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. No thread receives more grants in a cycle than its limit.
- R7: With policy code 1, every ready branch ranks ahead of every non-branch. Within each of the two groups, age order applies.
- R8: With policy code 2, every speculative entry ranks behind every non-speculative one. Policy code 3 behaves like code 0.
- R9: A slot's completion cycle equals the cycle count plus the latency of the unit type: 1, 3, 2 or 5 for codes 0 to 3. The count is 0 on the first cycle after reset and rises by one each clock.
- R10: An entry blocked by its unit limit or its thread cap does not stop entries of lower priority from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Ordering policy code |
| cap_sel_i | input | 2 | Per-thread issue limit code |
| ent_valid_i | input | 16 | Queue entry valid bits |
| ent_ready_i | input | 16 | Operands-ready bits |
| ent_tid_i | input | 16x2 | Thread id of each entry |
| ent_age_i | input | 16x8 | Age stamp of each entry (smaller is older) |
| ent_utype_i | input | 16x2 | Unit-type code of each entry |
| ent_branch_i | input | 16 | Branch flag of each entry |
| ent_spec_i | input | 16 | Speculative flag of each entry |
| grant_o | output | 16 | Entries issued this cycle |
| slot_vld_o | output | 8 | Issue slot in use |
| slot_idx_o | output | 8x4 | Queue index held by each slot |
| slot_done_o | output | 8x16 | Completion cycle for each slot, 0 when the slot is idle |

## Verification
On every cycle, the checker confirms that grants respect validity and readiness, the width limit, the unit-type limits and the thread cap. It also confirms that the slots are packed from slot 0, that the cycle count steps by one, and that nothing issues during reset. Those checks show only that a choice is legal. Whether it is the right choice (age order, branches promoted, speculative entries held back, a skip past a blocked entry, and the exact completion cycle) can only be shown by the bench's scenarios, which compare grant masks and slot contents against hand-derived values.

// File: rtl/smt_iss_pkg.sv
package smt_iss_pkg;
    typedef enum logic [1:0] {
        UT_ALU = 2'd0,
        UT_MUL = 2'd1,
        UT_MEM = 2'd2,
        UT_FP  = 2'd3
    } unit_t;

    typedef enum logic [1:0] {
        POL_OLDEST   = 2'd0,
        POL_BRANCH   = 2'd1,
        POL_SPECLAST = 2'd2,
        POL_RSVD     = 2'd3
    } policy_t;
endpackage

// File: rtl/smt_iss_rank.sv
module smt_iss_rank
    import smt_iss_pkg::*;
#(
    parameter int AW  = 8,
    parameter int IW  = 4,
    parameter int IDX = 0,
    localparam int KW = 1 + AW + IW
) (
    input  logic [1:0]    policy,
    input  logic [AW-1:0] age,
    input  logic          branch,
    input  logic          spec,
    output logic [KW-1:0] key
);
    logic cls;

    always_comb begin
        unique case (policy_t'(policy))
            POL_BRANCH:   cls = ~branch;
            POL_SPECLAST: cls = spec;
            default:      cls = 1'b0;
        endcase
    end

    // lower key wins: class, then age, then queue index
    assign key = {cls, age, IW'(IDX)};
endmodule

// File: rtl/smt_iss_pick.sv
module smt_iss_pick #(
    parameter int N       = 16,
    parameter int W       = 8,
    parameter int TN      = 4,
    parameter int TW      = 2,
    parameter int KW      = 13,
    parameter int IW      = 4,
    parameter int CW      = 16,
    parameter int N_ALU   = 4,
    parameter int N_MUL   = 1,
    parameter int N_MEM   = 3,
    parameter int N_FP    = 2,
    parameter int LAT_ALU = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_MEM = 2,
    parameter int LAT_FP  = 5,
    localparam int CNT_W  = $clog2(W + 1)
) (
    input  logic [N-1:0]          cand,
    input  logic [N-1:0][1:0]     utype,
    input  logic [N-1:0][TW-1:0]  tid,
    input  logic [N-1:0][KW-1:0]  key,
    input  logic [CNT_W-1:0]      cap,
    input  logic [CW-1:0]         cyc,
    output logic [N-1:0]          grant,
    output logic [W-1:0]          slot_vld,
    output logic [W-1:0][IW-1:0]  slot_idx,
    output logic [W-1:0][CW-1:0]  slot_done
);
    function automatic logic [CNT_W-1:0] limit_of(input logic [1:0] t);
        case (t)
            2'd0:    return CNT_W'(N_ALU);
            2'd1:    return CNT_W'(N_MUL);
            2'd2:    return CNT_W'(N_MEM);
            default: return CNT_W'(N_FP);
        endcase
    endfunction

    function automatic logic [CW-1:0] lat_of(input logic [1:0] t);
        case (t)
            2'd0:    return CW'(LAT_ALU);
            2'd1:    return CW'(LAT_MUL);
            2'd2:    return CW'(LAT_MEM);
            default: return CW'(LAT_FP);
        endcase
    endfunction

    logic [N-1:0]             taken;
    logic [3:0][CNT_W-1:0]    type_cnt;
    logic [TN-1:0][CNT_W-1:0] thr_cnt;
    logic                     found;
    logic [IW-1:0]            best;

    always_comb begin
        taken     = '0;
        type_cnt  = '0;
        thr_cnt   = '0;
        slot_vld  = '0;
        slot_idx  = '0;
        slot_done = '0;
        found     = 1'b0;
        best      = '0;
        for (int s = 0; s < W; s++) begin
            found = 1'b0;
            best  = '0;
            for (int e = 0; e < N; e++) begin
                if (cand[e] && !taken[e]
                    && type_cnt[utype[e]] < limit_of(utype[e])
                    && thr_cnt[tid[e]] < cap) begin
                    if (!found || key[e] < key[best]) begin
                        best  = IW'(e);
                        found = 1'b1;
                    end
                end
            end
            if (found) begin
                taken[best]            = 1'b1;
                type_cnt[utype[best]]  = type_cnt[utype[best]] + CNT_W'(1);
                thr_cnt[tid[best]]     = thr_cnt[tid[best]] + CNT_W'(1);
                slot_vld[s]            = 1'b1;
                slot_idx[s]            = best;
                slot_done[s]           = cyc + lat_of(utype[best]);
            end
        end
        grant = taken;
    end
endmodule

// File: rtl/smt_issue_sched.sv
module smt_issue_sched #(
    parameter int N       = 16,
    parameter int W       = 8,
    parameter int TN      = 4,
    parameter int AW      = 8,
    parameter int CW      = 16,
    parameter int N_ALU   = 4,
    parameter int N_MUL   = 1,
    parameter int N_MEM   = 3,
    parameter int N_FP    = 2,
    parameter int LAT_ALU = 1,
    parameter int LAT_MUL = 3,
    parameter int LAT_MEM = 2,
    parameter int LAT_FP  = 5,
    localparam int TW     = $clog2(TN),
    localparam int IW     = $clog2(N),
    localparam int KW     = 1 + AW + IW,
    localparam int CNT_W  = $clog2(W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            policy_i,
    input  logic [1:0]            cap_sel_i,
    input  logic [N-1:0]          ent_valid_i,
    input  logic [N-1:0]          ent_ready_i,
    input  logic [N-1:0][TW-1:0]  ent_tid_i,
    input  logic [N-1:0][AW-1:0]  ent_age_i,
    input  logic [N-1:0][1:0]     ent_utype_i,
    input  logic [N-1:0]          ent_branch_i,
    input  logic [N-1:0]          ent_spec_i,
    output logic [N-1:0]          grant_o,
    output logic [W-1:0]          slot_vld_o,
    output logic [W-1:0][IW-1:0]  slot_idx_o,
    output logic [W-1:0][CW-1:0]  slot_done_o
);
    logic [CW-1:0]         cyc_q;
    logic [N-1:0]          cand;
    logic [N-1:0][KW-1:0]  key;
    logic [CNT_W-1:0]      cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + CW'(1);
    end

    assign cand = ent_valid_i & ent_ready_i & {N{rst_n}};
    assign cap  = CNT_W'(4'd1 << cap_sel_i);

    for (genvar g = 0; g < N; g++) begin : g_rank
        smt_iss_rank #(.AW(AW), .IW(IW), .IDX(g)) u_rank (
            .policy (policy_i),
            .age    (ent_age_i[g]),
            .branch (ent_branch_i[g]),
            .spec   (ent_spec_i[g]),
            .key    (key[g])
        );
    end

    smt_iss_pick #(
        .N(N), .W(W), .TN(TN), .TW(TW), .KW(KW), .IW(IW), .CW(CW),
        .N_ALU(N_ALU), .N_MUL(N_MUL), .N_MEM(N_MEM), .N_FP(N_FP),
        .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_MEM(LAT_MEM), .LAT_FP(LAT_FP)
    ) u_pick (
        .cand      (cand),
        .utype     (ent_utype_i),
        .tid       (ent_tid_i),
        .key       (key),
        .cap       (cap),
        .cyc       (cyc_q),
        .grant     (grant_o),
        .slot_vld  (slot_vld_o),
        .slot_idx  (slot_idx_o),
        .slot_done (slot_done_o)
    );
endmodule

// File: rtl/smt_issue_sched_chk.sv
module smt_issue_sched_chk #(
    parameter int N     = 16,
    parameter int W     = 8,
    parameter int TN    = 4,
    parameter int TW    = 2,
    parameter int CW    = 16,
    parameter int N_ALU = 4,
    parameter int N_MUL = 1,
    parameter int N_MEM = 3,
    parameter int N_FP  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cap_sel,
    input logic [N-1:0]         valid,
    input logic [N-1:0]         ready,
    input logic [N-1:0][TW-1:0] tid,
    input logic [N-1:0][1:0]    utype,
    input logic [N-1:0]         grant,
    input logic [W-1:0]         slot_vld,
    input logic [CW-1:0]        cyc
);
    int n_alu, n_mul, n_mem, n_fp;
    logic thr_over;
    int tcount [TN];

    always_comb begin
        n_alu = 0; n_mul = 0; n_mem = 0; n_fp = 0;
        thr_over = 1'b0;
        for (int t = 0; t < TN; t++) tcount[t] = 0;
        for (int e = 0; e < N; e++) begin
            if (grant[e]) begin
                case (utype[e])
                    2'd0:    n_alu++;
                    2'd1:    n_mul++;
                    2'd2:    n_mem++;
                    default: n_fp++;
                endcase
                tcount[tid[e]]++;
            end
        end
        for (int t = 0; t < TN; t++)
            if (tcount[t] > (1 << cap_sel)) thr_over = 1'b1;
    end

    always @(posedge clk) begin
        if (rst_n == 1'b0)
            assert_reset_quiet_R1: assert (grant == '0 && slot_vld == '0);
    end

    assert_grant_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(valid & ready)) == '0);

    assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= W && $countones(slot_vld) == $countones(grant));

    assert_slots_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_vld + W'(1)) & slot_vld) == '0);

    assert_unit_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        n_alu <= N_ALU && n_mul <= N_MUL && n_mem <= N_MEM && n_fp <= N_FP);

    assert_thread_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_over);

    assert_cycle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc == $past(cyc) + CW'(1));
endmodule

bind smt_issue_sched smt_issue_sched_chk #(
    .N(N), .W(W), .TN(TN), .TW(TW), .CW(CW),
    .N_ALU(N_ALU), .N_MUL(N_MUL), .N_MEM(N_MEM), .N_FP(N_FP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_sel  (cap_sel_i),
    .valid    (ent_valid_i),
    .ready    (ent_ready_i),
    .tid      (ent_tid_i),
    .utype    (ent_utype_i),
    .grant    (grant_o),
    .slot_vld (slot_vld_o),
    .cyc      (cyc_q)
);

// File: tb/test_smt_issue_sched.sv
module test_smt_issue_sched;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16, W = 8, TW = 2, AW = 8, IW = 4, CW = 16;

    typedef struct packed {
        logic [1:0]  pol;
        logic [1:0]  cap;
        logic [15:0] vld;
        logic [31:0] ut;
        logic [15:0] exp;
        logic [3:0]  s0;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VT [NV] = '{
        '{2'd0, 2'd3, 16'hFFFF, 32'h0000_0000, 16'hF000, 4'd15},
        '{2'd2, 2'd3, 16'hFFFF, 32'h0000_0000, 16'h3C00, 4'd13},
        '{2'd1, 2'd3, 16'hFFFF, 32'h0000_0000, 16'hE004, 4'd2},
        '{2'd0, 2'd0, 16'h3333, 32'h0000_0000, 16'h3000, 4'd13},
        '{2'd0, 2'd1, 16'h3333, 32'h0000_0000, 16'h3300, 4'd13},
        '{2'd0, 2'd3, 16'hFFFF, 32'h5555_5555, 16'h8000, 4'd15},
        '{2'd0, 2'd3, 16'hFFFF, 32'hFFFF_FFFF, 16'hC000, 4'd15},
        '{2'd0, 2'd3, 16'hFFFF, 32'hAAAA_AAAA, 16'hE000, 4'd15},
        '{2'd0, 2'd3, 16'hFFFF, 32'h006A_F000, 16'hFF00, 4'd15},
        '{2'd0, 2'd3, 16'hFFFF, 32'h5000_0000, 16'hBC00, 4'd15},
        '{2'd3, 2'd3, 16'hFFFF, 32'h0000_0000, 16'hF000, 4'd15}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy, cap_sel;
    logic [N-1:0] valid, ready, branch, spec;
    logic [N-1:0][TW-1:0] tid;
    logic [N-1:0][AW-1:0] age;
    logic [N-1:0][1:0] utype;
    logic [N-1:0] grant;
    logic [W-1:0] slot_vld;
    logic [W-1:0][IW-1:0] slot_idx;
    logic [W-1:0][CW-1:0] slot_done;
    int total = 0, bad = 0;
    int bcyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) bcyc <= rst_n ? bcyc + 1 : 0;

    smt_issue_sched i_smt_issue_sched (
        .clk(clk), .rst_n(rst_n), .policy_i(policy), .cap_sel_i(cap_sel),
        .ent_valid_i(valid), .ent_ready_i(ready), .ent_tid_i(tid),
        .ent_age_i(age), .ent_utype_i(utype), .ent_branch_i(branch),
        .ent_spec_i(spec), .grant_o(grant), .slot_vld_o(slot_vld),
        .slot_idx_o(slot_idx), .slot_done_o(slot_done)
    );

    function automatic int lat_of(input logic [1:0] t);
        case (t)
            2'd0: return 1;
            2'd1: return 3;
            2'd2: return 2;
            default: return 5;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R5"; 1: return "R8"; 2: return "R7";
            3, 4: return "R6"; 5, 6, 7: return "R4";
            8: return "R3"; 9: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic base_fields();
        for (int e = 0; e < N; e++) begin
            tid[e]    = TW'(e % 4);
            age[e]    = AW'(40 - e);
            branch[e] = (e == 2);
            spec[e]   = (e >= 14);
        end
        ready = '1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        base_fields();
        policy = 2'd0; cap_sel = 2'd3; valid = '1; utype = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 grant in reset", 32'(grant), 32'h0);
        check("R1 slots in reset", 32'(slot_vld), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            policy = VT[i].pol; cap_sel = VT[i].cap;
            valid = VT[i].vld; utype = VT[i].ut;
            #1;
            check(tag_of(i), 32'(grant), 32'(VT[i].exp));
            check("R3 slot0 index", 32'(slot_idx[0]), 32'(VT[i].s0));
            check("R9 slot0 done", 32'(slot_done[0]),
                  32'(bcyc + lat_of(VT[i].ut[2*VT[i].s0 +: 2])));
            if (i == 8) check("R3 slot count", 32'($countones(slot_vld)), 32'd8);
        end

        @(negedge clk);
        policy = 2'd0; cap_sel = 2'd3; valid = '1; utype = '0;
        ready = 16'h3FFF;
        #1;
        check("R2 not ready skipped", 32'(grant), 32'h3C00);

        @(negedge clk);
        ready = '1;
        for (int e = 0; e < N; e++) age[e] = AW'(7);
        #1;
        check("R5 tie by index", 32'(grant), 32'h000F);
        check("R5 tie slot0", 32'(slot_idx[0]), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule